// File: doc/BRIEF.md
# Dual-Mode Peripheral Slot Bridge

This block sits between an 8-bit peripheral-slot register window of sixteen byte offsets and two back-ends. The first back-end is a network controller with a 16-bit register port. The second is a two-wire serial EEPROM driven by bit-banging. A write-only mode flag, loaded through the top offset of the window, chooses which back-end the window maps to. The flag starts in network mode after reset.

In network mode each byte access becomes a single-lane access on the controller port. The register index is the byte offset with its lowest bit dropped, and that lowest bit picks the lane. In EEPROM mode four offsets drive or release the clock and data lines, one offset reads back the data line, and the top offset returns a fixed identification byte. Both lines are open-drain, so "high" means released. The controller interrupt is passed to the slot interrupt line through one register stage.

Top module: `slot_bridge`

## Requirements
- R1: A write (sel=1, wr=1) to offset 0xF loads the mode flag from wdata bit 0 in either mode (1 = EEPROM mode, 0 = network mode). That write raises neither nc_wr nor nc_rd.
- R2: After synchronous active-low reset the bridge is in network mode, scl_pull_low and sda_pull_low are 0 (both lines released), and slot_irq is 0.
- R3: In EEPROM mode, a write to offset 0x4 sets scl_pull_low, 0x5 clears it, 0x6 sets sda_pull_low and 0x7 clears it. Each change shows at the clock edge that ends the write.
- R4: In EEPROM mode, a read of offset 0x8 returns 0xFE with bit 0 equal to the current sda_in level.
- R5: In EEPROM mode, a read of offset 0xF returns 0x33, and a read of any offset other than 0x8 and 0xF returns 0xFF.
- R6: In network mode, nc_idx equals offset bits [3:1] during an access. Offset bit 0 selects the high byte lane (1) or the low byte lane (0).
- R7: In network mode, a write to offsets 0x0 to 0xE raises nc_wr for that cycle. nc_be has exactly one bit set: bit 1 for the high lane, bit 0 for the low lane. nc_wdata carries wdata on the selected lane and zero on the other lane.
- R8: In network mode, a read of any offset (0xF included) raises nc_rd and returns nc_rdata[15:8] for odd offsets or nc_rdata[7:0] for even offsets.
- R9: slot_irq equals nc_irq as it was one clock earlier.
- R10: In EEPROM mode, no access raises nc_wr or nc_rd. In EEPROM mode, writes to offsets other than 0x4 to 0x7 and 0xF leave both line controls unchanged. In network mode, writes leave both line controls unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Device-select strobe, one access per cycle |
| wr | input | 1 | 1 = write, 0 = read |
| ofs | input | 4 | Byte offset within the window |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, valid while sel=1 and wr=0 |
| nc_idx | output | 3 | Controller register index |
| nc_wdata | output | 16 | Controller write data, with only the active lane loaded |
| nc_be | output | 2 | Controller byte enables, [1] = high lane |
| nc_wr | output | 1 | Controller write strobe |
| nc_rd | output | 1 | Controller read strobe |
| nc_rdata | input | 16 | Controller read data |
| nc_irq | input | 1 | Controller interrupt |
| slot_irq | output | 1 | Slot interrupt output |
| scl_pull_low | output | 1 | 1 = pull the clock line low, 0 = release it |
| sda_pull_low | output | 1 | 1 = pull the data line low, 0 = release it |
| sda_in | input | 1 | Wired data-line level |

## Verification
A wrong mode flag shows at once on the first later access. Reads return 0xFF or 0x33 where controller bytes are expected, or controller strobes appear where they should be absent. A stuck or mis-decoded line control shows on scl_pull_low or sda_pull_low right after the edge that ends the write. It also shows on the next read of offset 0x8, because the bench's open-drain model feeds that line back. A lane or index error shows in the same cycle as the access, on nc_be, nc_idx, nc_wdata or rdata. Interrupt latency errors show one edge after nc_irq changes.

// File: rtl/slot_bridge_pkg.sv
// Shared constants for the dual-mode slot bridge: window geometry,
// the offsets decoded in EEPROM mode, and the fixed read-back bytes.
package slot_bridge_pkg;
    localparam int OFS_W  = 4;
    localparam int BYTE_W = 8;
    localparam int NC_W   = 16;

    localparam logic [OFS_W-1:0] OFS_CLK_PULL = 4'h4;
    localparam logic [OFS_W-1:0] OFS_CLK_FREE = 4'h5;
    localparam logic [OFS_W-1:0] OFS_DAT_PULL = 4'h6;
    localparam logic [OFS_W-1:0] OFS_DAT_FREE = 4'h7;
    localparam logic [OFS_W-1:0] OFS_DAT_SENSE = 4'h8;
    localparam logic [OFS_W-1:0] OFS_MODE     = 4'hF;

    localparam logic [BYTE_W-1:0] ID_BYTE    = 8'h33;
    localparam logic [BYTE_W-1:0] EMPTY_BYTE = 8'hFF;
endpackage

// File: rtl/sbr_mode_reg.sv
// Write-only mode flag. It assumes the caller decodes the mode-offset write
// strobe. The flag clears to network mode (0) on reset.
module sbr_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_bit,
    output logic eeprom_mode
);
    // Purpose: hold the selected back-end.
    always_ff @(posedge clk) begin
        if (!rst_n)    eeprom_mode <= 1'b0;
        else if (load) eeprom_mode <= load_bit;
    end

    // R1
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> eeprom_mode == $past(load_bit));
    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(eeprom_mode));
endmodule

// File: rtl/sbr_lane_bridge.sv
// Combinational byte-to-lane bridge. It assumes NC_W is a multiple of BYTE_W
// and the number of lanes is a power of two. The low offset bits pick the
// lane and the upper bits form the register index.
module sbr_lane_bridge #(
    parameter int OFS_W  = 4,
    parameter int BYTE_W = 8,
    parameter int NC_W   = 16,
    localparam int LANES  = NC_W / BYTE_W,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int IDX_W  = OFS_W - LANE_W
) (
    input  logic              en,
    input  logic              sel,
    input  logic              wr,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [NC_W-1:0]   nc_rdata,
    output logic [IDX_W-1:0]  nc_idx,
    output logic [NC_W-1:0]   nc_wdata,
    output logic [LANES-1:0]  nc_be,
    output logic              nc_wr,
    output logic              nc_rd,
    output logic [BYTE_W-1:0] rd_byte
);
    logic [LANE_W-1:0] lane;

    // Purpose: split the offset into lane and index and raise the strobes.
    always_comb begin
        lane   = ofs[LANE_W-1:0];
        nc_idx = ofs[OFS_W-1:LANE_W];
        nc_wr  = en && sel && wr;
        nc_rd  = en && sel && !wr;
    end

    // Purpose: one generated slice per lane for write data and byte enable.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            nc_be[l] = nc_wr && (lane == LANE_W'(l));
            nc_wdata[l*BYTE_W +: BYTE_W] = (lane == LANE_W'(l)) ? wdata : '0;
        end
    end

    // Purpose: return the selected lane of the controller data.
    always_comb rd_byte = nc_rdata[lane*BYTE_W +: BYTE_W];
endmodule

// File: rtl/sbr_twowire_port.sv
// Bit-bang port for a two-wire EEPROM. The line controls are open-drain
// pull-low flags. It assumes the caller gates en with EEPROM mode. Read data
// is combinational from the offset and the wired data line.
module sbr_twowire_port
    import slot_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sel,
    input  logic              wr,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              sda_in,
    output logic              scl_pull_low,
    output logic              sda_pull_low,
    output logic [BYTE_W-1:0] rd_byte
);
    logic wr_hit;

    // Purpose: qualify a write aimed at this port.
    always_comb wr_hit = en && sel && wr;

    // Purpose: update the open-drain pull flags from the decoded offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pull_low <= 1'b0;
            sda_pull_low <= 1'b0;
        end else if (wr_hit) begin
            case (ofs)
                OFS_CLK_PULL: scl_pull_low <= 1'b1;
                OFS_CLK_FREE: scl_pull_low <= 1'b0;
                OFS_DAT_PULL: sda_pull_low <= 1'b1;
                OFS_DAT_FREE: sda_pull_low <= 1'b0;
                default: ;
            endcase
        end
    end

    // Purpose: read-back mux for sense, identification and empty offsets.
    always_comb begin
        case (ofs)
            OFS_DAT_SENSE: rd_byte = {EMPTY_BYTE[BYTE_W-1:1], sda_in};
            OFS_MODE:      rd_byte = ID_BYTE;
            default:       rd_byte = EMPTY_BYTE;
        endcase
    end

    // R3
    clk_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && ofs == OFS_CLK_PULL) |=> scl_pull_low);
    // R3
    clk_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && ofs == OFS_CLK_FREE) |=> !scl_pull_low);
    // R3
    dat_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && ofs == OFS_DAT_PULL) |=> sda_pull_low);
    // R3
    dat_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && ofs == OFS_DAT_FREE) |=> !sda_pull_low);
    // R10
    lines_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable({scl_pull_low, sda_pull_low}));
endmodule

// File: rtl/sbr_irq_relay.sv
// One-stage registered relay from the controller interrupt to the slot line.
// It assumes nc_irq is synchronous to clk.
module sbr_irq_relay (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_in,
    output logic irq_out
);
    // Purpose: register the interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= irq_in;
    end

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> irq_out == $past(irq_in));
endmodule

// File: rtl/slot_bridge.sv
// Top of the dual-mode slot bridge. It decodes the mode write, steers each
// access to the lane bridge or the two-wire port, and selects the read data.
// It assumes single-cycle accesses qualified by sel.
module slot_bridge
    import slot_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [2:0]        nc_idx,
    output logic [NC_W-1:0]   nc_wdata,
    output logic [1:0]        nc_be,
    output logic              nc_wr,
    output logic              nc_rd,
    input  logic [NC_W-1:0]   nc_rdata,
    input  logic              nc_irq,
    output logic              slot_irq,
    output logic              scl_pull_low,
    output logic              sda_pull_low,
    input  logic              sda_in
);
    logic              eeprom_mode;
    logic              mode_wr;
    logic              lane_en;
    logic [BYTE_W-1:0] lane_rd;
    logic [BYTE_W-1:0] wire_rd;

    // Purpose: decode the mode write and gate the network path.
    always_comb begin
        mode_wr = sel && wr && (ofs == OFS_MODE);
        lane_en = !eeprom_mode && !mode_wr;
    end

    sbr_mode_reg u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (mode_wr),
        .load_bit    (wdata[0]),
        .eeprom_mode (eeprom_mode)
    );

    sbr_lane_bridge #(.OFS_W(OFS_W), .BYTE_W(BYTE_W), .NC_W(NC_W)) u_lane (
        .en       (lane_en),
        .sel      (sel),
        .wr       (wr),
        .ofs      (ofs),
        .wdata    (wdata),
        .nc_rdata (nc_rdata),
        .nc_idx   (nc_idx),
        .nc_wdata (nc_wdata),
        .nc_be    (nc_be),
        .nc_wr    (nc_wr),
        .nc_rd    (nc_rd),
        .rd_byte  (lane_rd)
    );

    sbr_twowire_port u_wire (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (eeprom_mode),
        .sel          (sel),
        .wr           (wr),
        .ofs          (ofs),
        .sda_in       (sda_in),
        .scl_pull_low (scl_pull_low),
        .sda_pull_low (sda_pull_low),
        .rd_byte      (wire_rd)
    );

    sbr_irq_relay u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (nc_irq),
        .irq_out (slot_irq)
    );

    // Purpose: pick the read byte from the active back-end.
    always_comb rdata = eeprom_mode ? wire_rd : lane_rd;

    // R7
    one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nc_wr |-> $countones(nc_be) == 1);
    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nc_wr, nc_rd}));
    // R10
    eeprom_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eeprom_mode |-> !(nc_wr || nc_rd));
    // R1
    mode_nofwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && ofs == OFS_MODE) |-> !nc_wr);
endmodule

// File: tb/slot_bridge_tb_top.sv
// Self-checking bench: sweeps every offset in both modes against a
// register-file controller model and an open-drain EEPROM data line.
module slot_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [3:0]  ofs = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [2:0]  nc_idx;
    logic [15:0] nc_wdata;
    logic [1:0]  nc_be;
    logic        nc_wr, nc_rd;
    logic [15:0] nc_rdata;
    logic        nc_irq = 1'b0;
    logic        slot_irq, scl_pull_low, sda_pull_low;
    logic        eep_pull = 1'b0;
    logic        sda_in;

    int total = 0, bad = 0;
    bit done = 1'b0;

    logic [15:0] model_reg [8];
    logic [15:0] exp_reg   [8];

    logic [7:0]  s_rd;
    logic [2:0]  s_idx;
    logic [15:0] s_wd;
    logic [1:0]  s_be;
    logic        s_wr, s_rdstb;

    always #4 clk = ~clk;

    assign sda_in   = ~sda_pull_low & ~eep_pull;
    assign nc_rdata = model_reg[nc_idx];

    slot_bridge dut_i (.*);

    // Controller register file model with byte enables.
    initial for (int i = 0; i < 8; i++) model_reg[i] = 16'h1357 * 16'(i + 1);
    always @(posedge clk) if (nc_wr) begin
        if (nc_be[0]) model_reg[nc_idx][7:0]  <= nc_wdata[7:0];
        if (nc_be[1]) model_reg[nc_idx][15:8] <= nc_wdata[15:8];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] o, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; ofs = o; wdata = d;
        #2;
        s_idx = nc_idx; s_wd = nc_wdata; s_be = nc_be; s_wr = nc_wr; s_rdstb = nc_rd;
        @(posedge clk); #1;
        sel = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] o);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; ofs = o;
        #2;
        s_rd = rdata; s_idx = nc_idx; s_wr = nc_wr; s_rdstb = nc_rd;
        @(posedge clk); #1;
        sel = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) exp_reg[i] = 16'h1357 * 16'(i + 1);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R2 reset state
        chk("R2 scl", {31'd0, scl_pull_low}, 0);
        chk("R2 sda", {31'd0, sda_pull_low}, 0);
        chk("R2 irq", {31'd0, slot_irq}, 0);
        do_read(4'h0);
        chk("R2 network mode", {31'd0, s_rdstb}, 1);

        // R6 R7: network write sweep
        for (int o = 0; o < 15; o++) begin
            logic [7:0] d;
            d = 8'(o * 37 + 11);
            do_write(4'(o), d);
            chk("R6 idx", {29'd0, s_idx}, o / 2);
            chk("R7 wr", {31'd0, s_wr}, 1);
            chk("R7 be", {30'd0, s_be}, (o % 2) ? 2 : 1);
            chk("R7 wdata", {16'd0, s_wd}, (o % 2) ? {16'd0, d, 8'd0} : {24'd0, d});
            chk("R10 lines net", {30'd0, scl_pull_low, sda_pull_low}, 0);
            if (o % 2) exp_reg[o / 2][15:8] = d; else exp_reg[o / 2][7:0] = d;
        end
        // R1: mode write to network is not forwarded
        do_write(4'hF, 8'h00);
        chk("R1 no fwd", {30'd0, s_wr, s_rdstb}, 0);

        // R8: network read sweep
        for (int o = 0; o < 16; o++) begin
            do_read(4'(o));
            chk("R8 rdstb", {31'd0, s_rdstb}, 1);
            chk("R6 idx rd", {29'd0, s_idx}, o / 2);
            chk("R8 rdata", {24'd0, s_rd},
                (o % 2) ? {24'd0, exp_reg[o / 2][15:8]} : {24'd0, exp_reg[o / 2][7:0]});
        end

        // R1: enter EEPROM mode
        do_write(4'hF, 8'hC1);
        chk("R1 no fwd ee", {30'd0, s_wr, s_rdstb}, 0);

        // R4 R5 R10: EEPROM read sweep
        for (int o = 0; o < 16; o++) begin
            do_read(4'(o));
            chk("R10 no rd", {31'd0, s_rdstb}, 0);
            chk("R5 R4 rdata", {24'd0, s_rd}, (o == 8) ? 8'hFF : (o == 15) ? 8'h33 : 8'hFF);
        end

        // R3 line controls
        do_write(4'h4, 8'h00);
        chk("R3 scl pull", {31'd0, scl_pull_low}, 1);
        chk("R10 no wr", {31'd0, s_wr}, 0);
        do_write(4'h6, 8'hFF);
        chk("R3 sda pull", {31'd0, sda_pull_low}, 1);
        do_read(4'h8);
        chk("R4 sense low", {24'd0, s_rd}, 8'hFE);
        // R10: other offsets leave the lines alone
        for (int o = 0; o < 15; o++) begin
            if (o < 4 || o > 7) begin
                do_write(4'(o), 8'h55);
                chk("R10 ignored", {30'd0, scl_pull_low, sda_pull_low}, 3);
                chk("R10 no wr ee", {31'd0, s_wr}, 0);
            end
        end
        do_write(4'h5, 8'h00);
        chk("R3 scl free", {31'd0, scl_pull_low}, 0);
        do_write(4'h7, 8'h00);
        chk("R3 sda free", {31'd0, sda_pull_low}, 0);
        do_read(4'h8);
        chk("R4 sense high", {24'd0, s_rd}, 8'hFF);
        eep_pull = 1'b1;
        do_read(4'h8);
        chk("R4 wired and", {24'd0, s_rd}, 8'hFE);
        eep_pull = 1'b0;

        // R1: bit 0 clear returns to network; R10 lines untouched there
        do_write(4'h6, 8'h00);
        do_write(4'hF, 8'hFE);
        do_read(4'h1);
        chk("R1 back to net", {24'd0, s_rd}, {24'd0, exp_reg[0][15:8]});
        do_write(4'h7, 8'h9A);
        chk("R10 net keeps sda", {31'd0, sda_pull_low}, 1);
        exp_reg[3][15:8] = 8'h9A;
        do_write(4'hF, 8'h03);
        do_read(4'hF);
        chk("R1 ee again", {24'd0, s_rd}, 8'h33);

        // R9 interrupt relay latency
        @(negedge clk); nc_irq = 1'b1; #1;
        chk("R9 not yet", {31'd0, slot_irq}, 0);
        @(posedge clk); #1;
        chk("R9 rise", {31'd0, slot_irq}, 1);
        @(negedge clk); nc_irq = 1'b0;
        @(posedge clk); #1;
        chk("R9 fall", {31'd0, slot_irq}, 0);

        finish_run();
    end
endmodule